// File: doc/BRIEF.md
# PHY Delay Register Access Port

This block lets software program a small file of 8-bit PHY delay and DLL settings through a single 32-bit control word. The word carries a 6-bit register address, 8 bits of write data, a write strobe and a read strobe. Hardware fills in two further fields: an 8-bit read-data field and an acknowledge bit.

To write a register, software first stores the address and data with both strobes low. It then stores the same word with the write strobe set and polls until the acknowledge bit is high. Finally it clears the strobe while leaving the address and data untouched. A read follows the same steps with the read strobe, and the addressed value appears in the read-data field as the acknowledge bit rises.

Accesses are strictly one at a time. After power-up or wake from sleep, one access is issued for each configured delay setting. The register file itself is part of the block. Its values drive the delay lines through a flat tap bus.

The acknowledge latency is a parameter (two cycles or more). It is meant to be short compared with a software polling limit of about 10 microseconds. The implemented addresses are set by a bit mask. The default implements 0x00 to 0x08 and 0x0B to 0x0D.

Top module: `phy_access_port`

## Requirements
- R1: After reset the control word reads as zero and every tap register is zero.
- R2: The control word reads back with the address in bits 5:0, write data in 15:8, read data in 23:16, write strobe in 24, read strobe in 25 and acknowledge in 26. Bits 7:6 and 31:27 read as zero, and bus writes to bits 23:16 and 26 have no effect.
- R3: When a bus write raises a strobe while both strobes were low and no access is pending, acknowledge rises on the ACK_LAT-th clock edge after the edge that stored the strobe (ACK_LAT = 4 by default). It is low on every edge before that one.
- R4: Acknowledge stays high while a strobe is held. It falls on the first clock edge after the edge that stored both strobes low.
- R5: A write access stores the write data into the addressed implemented register no later than the edge on which acknowledge rises. No other register changes.
- R6: A read access places the addressed register value in the read-data field on the edge on which acknowledge rises. The field then holds until the next read access.
- R7: A write to an unimplemented address is acknowledged but changes no register. A read from an unimplemented address returns zero.
- R8: While an access is acknowledged and its strobe is still held, bus writes that change the fields or raise the other strobe start no new access. They change no register and do not change the read data.
- R9: Address and write data are captured when the access starts. Rewriting the fields before acknowledge does not redirect the access.
- R10: If both strobes are raised together, the access is a write, and the read-data field is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write enable for the control word |
| busWrData | input | 32 | Bus write data for the control word |
| busRdData | output | 32 | Current control word, including read data and acknowledge |
| phyTaps | output | NUM_REGS*8 | All tap registers, register n in bits 8n+7:8n |

## Verification
A wrong state in the access sequencer shows up on the acknowledge bit. The bit rises one or more edges early or late, stays stuck high after the strobe drops, or rises a second time while the strobe is still held. The bench sees any of these within a few cycles of the bus write that caused it.

A wrong capture point or a wrong decode in the register file shows up on the tap bus and in the read-data field. The value lands in the wrong register, or a stray write changes a register when it should not, and this is visible on the edge that acknowledge rises. Comparing every tap after each access catches such corruption before the next access begins.

// File: rtl/phy_access_pkg.sv
`timescale 1ns/1ps
package phy_access_pkg;
  // Control-word field positions: software decodes these, so they are fixed.
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int ADDR_LSB  = 0;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WSTB_BIT  = 24;
  localparam int RSTB_BIT  = 25;
  localparam int ACK_BIT   = 26;

  // Strobes from sequencer to register file.
  typedef struct packed {
    logic              commitWr;
    logic              commitRd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } phyCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ACKED = 2'd2
  } portState_t;
endpackage

// File: rtl/phy_reg_file.sv
`timescale 1ns/1ps
module phy_reg_file
  import phy_access_pkg::*;
#(
  parameter int          NUM_REGS  = 14,
  parameter logic [63:0] IMPL_MASK = 64'h39FF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  phyCmd_t                    cmd,
  output logic [DATA_W-1:0]          rdVal,
  output logic [NUM_REGS*DATA_W-1:0] taps
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (IMPL_MASK[g]) begin : g_impl
        always_ff @(posedge clk) begin
          if (!rstN) begin
            regQ[g] <= '0;
          end else if (cmd.commitWr && (cmd.addr == ADDR_W'(g))) begin
            regQ[g] <= cmd.wdata;
          end
        end
      end else begin : g_hole
        assign regQ[g] = '0;
      end
    end
  endgenerate

  logic addrInRange;
  assign addrInRange = (int'(cmd.addr) < NUM_REGS);

  always_comb begin
    rdVal = '0;
    if (addrInRange) begin
      rdVal = regQ[cmd.addr[IDX_W-1:0]];
    end
  end

  assign taps = regQ;

  // R7: an address outside the implemented set always reads as zero
  a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!(addrInRange && IMPL_MASK[cmd.addr])) |-> (rdVal == '0));

  // R5: tap contents change only after a write commit
  a_r5_taps_move_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(regQ)) |-> $past(cmd.commitWr));
endmodule

// File: rtl/phy_port_ctrl.sv
`timescale 1ns/1ps
module phy_port_ctrl
  import phy_access_pkg::*;
#(
  parameter int ACK_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic [DATA_W-1:0] rdVal,
  output phyCmd_t           cmd,
  output logic [31:0]       busRdData
);
  localparam int CNT_W = $clog2(ACK_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LAT - 1);

  // Software-owned fields.
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              wrStbQ;
  logic              rdStbQ;

  // Hardware-owned fields.
  logic [DATA_W-1:0] rdataQ;
  logic              ackQ;

  // Sequencer state and access snapshot.
  portState_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] snapAddr;
  logic [DATA_W-1:0] snapData;
  logic              snapIsWr;

  logic stbLevel;
  logic atLast;
  assign stbLevel = wrStbQ | rdStbQ;
  assign atLast   = (state == ST_WAIT) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wrStbQ <= 1'b0;
      rdStbQ <= 1'b0;
    end else if (busWrEn) begin
      addrQ  <= busWrData[ADDR_LSB +: ADDR_W];
      wdataQ <= busWrData[WDATA_LSB +: DATA_W];
      wrStbQ <= busWrData[WSTB_BIT];
      rdStbQ <= busWrData[RSTB_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      snapAddr <= '0;
      snapData <= '0;
      snapIsWr <= 1'b0;
      ackQ     <= 1'b0;
      rdataQ   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          // Return to idle requires a low strobe, so a high level here is a fresh edge.
          if (stbLevel) begin
            state    <= ST_WAIT;
            cnt      <= CNT_W'(1);
            snapAddr <= addrQ;
            snapData <= wdataQ;
            snapIsWr <= wrStbQ;
          end
        end
        ST_WAIT: begin
          if (cnt == CNT_LAST) begin
            state <= ST_ACKED;
            ackQ  <= 1'b1;
            if (!snapIsWr) begin
              rdataQ <= rdVal;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ACKED: begin
          if (!stbLevel) begin
            state <= ST_IDLE;
            ackQ  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.commitWr = atLast && snapIsWr;
    cmd.commitRd = atLast && !snapIsWr;
    cmd.addr     = snapAddr;
    cmd.wdata    = snapData;
  end

  always_comb begin
    busRdData = '0;
    busRdData[ADDR_LSB +: ADDR_W]   = addrQ;
    busRdData[WDATA_LSB +: DATA_W]  = wdataQ;
    busRdData[RDATA_LSB +: DATA_W]  = rdataQ;
    busRdData[WSTB_BIT]             = wrStbQ;
    busRdData[RSTB_BIT]             = rdStbQ;
    busRdData[ACK_BIT]              = ackQ;
  end

  // R3: every commit is followed by acknowledge on the next edge
  a_r3_commit_then_ack: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commitWr || cmd.commitRd) |=> ackQ);

  // R4: acknowledge is only high when a strobe was high one edge earlier
  a_r4_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> $past(stbLevel));

  // R4: a released strobe clears acknowledge on the next edge
  a_r4_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ && !stbLevel) |=> !ackQ);

  // R8: no commit while an access is still acknowledged
  a_r8_no_commit_while_acked: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> !(cmd.commitWr || cmd.commitRd));

  // R6: read data moves only after a read commit
  a_r6_rdata_moves_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rdataQ)) |-> $past(cmd.commitRd));
endmodule

// File: rtl/phy_access_port.sv
`timescale 1ns/1ps
module phy_access_port
  import phy_access_pkg::*;
#(
  parameter int          ACK_LAT   = 4,
  parameter int          NUM_REGS  = 14,
  parameter logic [63:0] IMPL_MASK = 64'h39FF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  output logic [NUM_REGS*8-1:0]  phyTaps
);
  phyCmd_t           cmd;
  logic [DATA_W-1:0] rdVal;

  phy_port_ctrl #(.ACK_LAT(ACK_LAT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .rdVal     (rdVal),
    .cmd       (cmd),
    .busRdData (busRdData)
  );

  phy_reg_file #(.NUM_REGS(NUM_REGS), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .rdVal (rdVal),
    .taps  (phyTaps)
  );
endmodule

// File: tb/phy_access_port_bench.sv
`timescale 1ns/1ps
module phy_access_port_bench;
  localparam int ACK_LAT  = 4;
  localparam int NUM_REGS = 14;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  busWrEn = 1'b0;
  logic [31:0]           busWrData = '0;
  logic [31:0]           busRdData;
  logic [NUM_REGS*8-1:0] phyTaps;

  phy_access_port u_phy_access_port (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .phyTaps(phyTaps)
  );

  always #10 clk = ~clk;

  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;
  logic [7:0] model [64];
  logic [7:0] lastRd = '0;

  function automatic bit isImpl(int a);
    return (a <= 8) || (a >= 11 && a <= 13);
  endfunction

  function automatic logic [31:0] mkWord(int a, logic [7:0] d, bit wr, bit rd);
    return {5'b0, 1'b0, rd, wr, 8'h00, d, 2'b00, 6'(a)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [31:0] w);
    @(negedge clk);
    busWrEn   = 1'b1;
    busWrData = w;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic checkTaps(string req);
    for (int i = 0; i < NUM_REGS; i++)
      chk(phyTaps[i*8 +: 8] == model[i], req, "tap", 32'(phyTaps[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic access(int a, logic [7:0] d, bit wr, bit rd);
    busWrite(mkWord(a, d, 1'b0, 1'b0));
    busWrite(mkWord(a, d, wr, rd));
    repeat (ACK_LAT - 1) @(negedge clk);
    chk(busRdData[26] == 1'b0, "R3", "ack early", 32'(busRdData[26]), 0);
    @(negedge clk);
    chk(busRdData[26] == 1'b1, "R3", "ack at latency", 32'(busRdData[26]), 1);
    if (wr) begin
      if (isImpl(a)) model[a] = d;
    end else if (rd) begin
      lastRd = isImpl(a) ? model[a] : 8'h00;
    end
    chk(busRdData[23:16] == lastRd, isImpl(a) ? "R6" : "R7", "rdata", 32'(busRdData[23:16]), 32'(lastRd));
    checkTaps(isImpl(a) ? "R5" : "R7");
    repeat (2) @(negedge clk);
    chk(busRdData[26] == 1'b1, "R4", "ack held", 32'(busRdData[26]), 1);
    busWrite(mkWord(a, d, 1'b0, 1'b0));
    chk(busRdData[26] == 1'b1, "R4", "ack before drop", 32'(busRdData[26]), 1);
    @(negedge clk);
    chk(busRdData[26] == 1'b0, "R4", "ack dropped", 32'(busRdData[26]), 0);
    chk(busRdData[23:16] == lastRd, "R6", "rdata hold", 32'(busRdData[23:16]), 32'(lastRd));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busRdData == 32'h0, "R1", "word", busRdData, 0);
    checkTaps("R1");

    // R5 / R6 directed
    access(0, 8'h12, 1'b1, 1'b0);
    access(13, 8'hE7, 1'b1, 1'b0);
    access(13, 8'h00, 1'b0, 1'b1);
    // R7 holes
    access(9, 8'h99, 1'b1, 1'b0);
    access(9, 8'h00, 1'b0, 1'b1);
    access(63, 8'hAB, 1'b1, 1'b0);
    access(0, 8'h00, 1'b0, 1'b1);

    // R9: fields rewritten during the wait do not redirect the access
    busWrite(mkWord(2, 8'hA5, 1'b0, 1'b0));
    busWrite(mkWord(2, 8'hA5, 1'b1, 1'b0));
    busWrite(mkWord(3, 8'h5A, 1'b1, 1'b0));
    repeat (ACK_LAT - 1) @(negedge clk);
    chk(busRdData[26] == 1'b1, "R9", "ack", 32'(busRdData[26]), 1);
    model[2] = 8'hA5;
    checkTaps("R9");

    // R8: new edge while acknowledged is ignored
    busWrite(mkWord(4, 8'h77, 1'b1, 1'b1));
    repeat (ACK_LAT + 2) @(negedge clk);
    checkTaps("R8");
    chk(busRdData[23:16] == lastRd, "R8", "rdata", 32'(busRdData[23:16]), 32'(lastRd));
    busWrite(mkWord(4, 8'h77, 1'b0, 1'b0));
    @(negedge clk);
    chk(busRdData[26] == 1'b0, "R8", "ack after release", 32'(busRdData[26]), 0);

    // R10: both strobes act as a write
    access(5, 8'h3C, 1'b1, 1'b1);
    access(5, 8'h00, 1'b0, 1'b1);

    // R2: field layout and hardware-owned bits not writable
    busWrite(32'hFCFF_FFFF);
    chk(busRdData == {8'h00, lastRd, 16'hFF3F}, "R2", "layout", busRdData, {8'h00, lastRd, 16'hFF3F});
    busWrite(32'h04FF_0611);
    chk(busRdData == {8'h00, lastRd, 16'h0611}, "R2", "hw bits", busRdData, {8'h00, lastRd, 16'h0611});
    busWrite(32'h0);

    // Random accesses
    for (int n = 0; n < 80; n++) begin
      int a;
      logic [7:0] d;
      bit wr;
      a  = (($urandom % 4) == 0) ? int'($urandom % 64) : int'($urandom % NUM_REGS);
      d  = 8'($urandom);
      wr = (($urandom % 10) < 6);
      access(a, d, wr, !wr);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule